// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged internal control registers of a processor core behind a single index. Each access presents an index together with a read strobe, a write strobe or both. Every register applies its own rule to the data written into it:

- some keep every bit;
- some keep only a field;
- some return to zero on any write;
- some may only be read;
- some may only be written.

An access that breaks one of these rules raises a fault flag instead of changing anything. One slot is a cycle counter. Its upper half is stored. Its lower half is a free-running live count.

The surrounding pipeline drives a speculation flag. While that flag is high, writes are dropped silently, so wrong-path instructions leave no trace. The read data and the fault flag are registered. Both appear one clock after the strobe and read zero on cycles with no access.

The index map is as follows:

| Index | Register | Write rule |
|---|---|---|
| 0-7 | Scratch | All bits kept |
| 8 | Handler base | All bits kept |
| 9 | Misc control | All bits kept |
| 10 | Exception return address | Bit 1 forced to zero |
| 11, 12 | Trap request, trap enable | Low 4 bits kept |
| 13, 14 | Instruction-side mode, data-side mode | Bits 4:3 kept |
| 15, 16 | Cache mode, miss-queue mode | Low 6 bits kept |
| 17 | Instruction address-space id | Bits 10:4 kept |
| 18 | Data address-space id | Bits 63:57 kept |
| 19, 20 | Exception summary, exception mask | Cleared by any write |
| 21, 22, 23 | Interrupt id, memory status, page-entry temp | Read-only |
| 24, 25 | Flush, invalidate | Write-only |
| 26 | Cycle counter | Upper half stored |
| 27-31 | Undefined | Fault on any access |

Top module: `priv_reg_bank`

## Requirements
- R1: After synchronous reset, every readable index reads zero, with two exceptions. Index 8 reads the parameter PAL_BASE_RST, which defaults to 0x4000. Index 9 reads 0x6.
- R2: Indices 0 to 9 store all 64 written bits. They read back with no fault.
- R3: A write to index 10 stores the data with bit 1 forced to zero.
- R4: Some writes keep only a field. Indices 11 and 12 keep mask 0xF. Indices 13 and 14 keep mask 0x18. Indices 15 and 16 keep mask 0x3F. Index 17 keeps mask 0x7F0. Index 18 keeps mask 0xFE00_0000_0000_0000. All other bits read zero.
- R5: Any write to index 19 or 20 leaves that register at zero, whatever the data.
- R6: A write to index 21, 22 or 23 raises the fault flag and changes nothing. Reads of these indices return the stored value with no fault.
- R7: A read of index 24 or 25 returns zero and raises the fault flag. A write to either index is accepted with no fault.
- R8: Indices 27 to 31 are undefined. A read returns zero and faults. A write faults.
- R9: While the speculation flag is high, a write changes no register and raises no fault.
- R10: A read of index 26 returns the stored upper 32 bits above the live count. The live count is zero at reset, increments on every clock, and wraps at 32 bits. The read samples the count on the clock edge that takes the strobe.
- R11: Read data and fault appear on the clock after the strobe. Both are zero after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_idx | input | IDX_W | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| spec_mode | input | 1 | Speculation flag; suppresses writes |
| rd_data | output | 64 | Registered read data |
| acc_fault | output | 1 | Registered fault flag |

## Verification
The assertions assume the following about the inputs:
- The strobes and the index are stable within a clock.
- A fault check is attributed to a single access type. The speculation-silence property therefore only claims quiet when no read is presented in the same cycle.

The stimulus respects these assumptions. It issues one read or one write per transaction, never both, and drives every input on the falling edge. A sweep covers all 32 indices with two complementary data patterns, repeats under the speculation flag, and revisits the counter slot at spread-out times.

// File: rtl/priv_reg_pkg.sv
// Package: shared register kinds and per-index attributes for the control bank.
// Assumes a 64-bit register width and a 32-bit live counter half.
package priv_reg_pkg;

    localparam int PRIV_DW     = 64;
    localparam int LIVE_W      = 32;
    localparam int NUM_DEFINED = 27;

    typedef enum logic [2:0] {
        K_NONE,   // undefined slot
        K_RW,     // masked read/write
        K_RO,     // read-only
        K_WO,     // write-only
        K_CLR,    // cleared by any write
        K_CC      // cycle counter: stored upper half, live lower half
    } reg_kind_e;

    // Classify an index.
    function automatic reg_kind_e kind_of(input int unsigned i);
        if (i >= NUM_DEFINED)           return K_NONE;
        if (i == 19 || i == 20)         return K_CLR;
        if (i >= 21 && i <= 23)         return K_RO;
        if (i == 24 || i == 25)         return K_WO;
        if (i == 26)                    return K_CC;
        return K_RW;
    endfunction

    // Bits kept on a write for masked read/write slots.
    function automatic logic [PRIV_DW-1:0] mask_of(input int unsigned i);
        case (i)
            10:      return ~64'h2;
            11, 12:  return 64'hF;
            13, 14:  return 64'h18;
            15, 16:  return 64'h3F;
            17:      return 64'h7F0;
            18:      return 64'hFE00_0000_0000_0000;
            default: return '1;
        endcase
    endfunction

    // Value a slot takes at reset.
    function automatic logic [PRIV_DW-1:0] reset_of(input int unsigned i,
                                                    input logic [PRIV_DW-1:0] pal_rst,
                                                    input logic [PRIV_DW-1:0] misc_rst);
        if (i == 8) return pal_rst;
        if (i == 9) return misc_rst;
        return '0;
    endfunction

endpackage

// File: rtl/priv_reg_decode.sv
// Module: classifies the presented index into a register kind.
// Assumes indices at or above NUM_DEFINED are undefined.
module priv_reg_decode
    import priv_reg_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    output reg_kind_e        kind
);

    // Look up the kind of the addressed slot.
    always_comb begin
        kind = kind_of(int'(idx));
    end

endmodule

// File: rtl/priv_live_ctr.sv
// Module: free-running live counter forming the lower half of the cycle counter.
// Assumes it counts every clock after reset and wraps at its width.
module priv_live_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);

    // Advance by one each clock, zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    assert_live_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count == $past(count) + 1'b1);

endmodule

// File: rtl/priv_reg_store.sv
// Module: storage slots of the bank, one generated per index, each applying its own write rule.
// Assumes the caller only raises we for writable kinds when the write is allowed.
module priv_reg_store
    import priv_reg_pkg::*;
#(
    parameter int                 IDX_W    = 5,
    parameter logic [PRIV_DW-1:0] PAL_RST  = 64'h4000,
    parameter logic [PRIV_DW-1:0] MISC_RST = 64'h6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [PRIV_DW-1:0] wdata,
    output logic [PRIV_DW-1:0] q_sel
);

    localparam int NREG = 1 << IDX_W;

    logic [PRIV_DW-1:0] q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam reg_kind_e          K = kind_of(g);
        localparam logic [PRIV_DW-1:0] M = mask_of(g);
        localparam logic [PRIV_DW-1:0] RV = reset_of(g, PAL_RST, MISC_RST);

        if (K == K_NONE || K == K_RO) begin : g_const
            assign q[g] = '0;
        end else begin : g_reg
            logic [PRIV_DW-1:0] r;
            logic               hit;
            assign hit  = we && (idx == IDX_W'(g));
            assign q[g] = r;

            // Capture the write through this slot's rule.
            always_ff @(posedge clk) begin
                if (!rst_n)   r <= RV;
                else if (hit) r <= (K == K_CLR) ? '0 : (wdata & M);
            end

            if (K == K_RW) begin : g_mask_chk
                assert_field_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (r & ~M) == '0);
            end
            if (K == K_CLR) begin : g_clr_chk
                assert_clear_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    hit |=> r == '0);
            end
        end
    end

    // Select the addressed slot.
    always_comb begin
        q_sel = q[idx];
    end

endmodule

// File: rtl/priv_reg_bank.sv
// Module: top of the privileged control register bank; applies fault rules and
// speculative write suppression, registers read data and fault flag.
// Assumes one index per cycle shared by the read and write strobes.
module priv_reg_bank
    import priv_reg_pkg::*;
#(
    parameter int                 IDX_W        = 5,
    parameter logic [PRIV_DW-1:0] PAL_BASE_RST = 64'h4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic               wr_en,
    input  logic [PRIV_DW-1:0] wr_data,
    input  logic               rd_en,
    input  logic               spec_mode,
    output logic [PRIV_DW-1:0] rd_data,
    output logic               acc_fault
);

    localparam logic [PRIV_DW-1:0] MISC_RST = 64'h6;

    reg_kind_e          kind;
    logic [PRIV_DW-1:0] q_sel;
    logic [LIVE_W-1:0]  live;
    logic               wr_live, wr_ok, wr_flt, rd_flt;
    logic [PRIV_DW-1:0] rd_val;

    priv_reg_decode #(.IDX_W(IDX_W)) u_dec (
        .idx  (acc_idx),
        .kind (kind)
    );

    priv_live_ctr #(.W(LIVE_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (live)
    );

    priv_reg_store #(.IDX_W(IDX_W), .PAL_RST(PAL_BASE_RST), .MISC_RST(MISC_RST)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .idx   (acc_idx),
        .wdata (wr_data),
        .q_sel (q_sel)
    );

    // Decide write permission and faults for this access.
    always_comb begin
        wr_live = wr_en && !spec_mode;
        wr_ok   = wr_live && (kind == K_RW || kind == K_WO || kind == K_CLR || kind == K_CC);
        wr_flt  = wr_live && (kind == K_NONE || kind == K_RO);
        rd_flt  = rd_en && (kind == K_NONE || kind == K_WO);
    end

    // Form the value a read returns.
    always_comb begin
        case (kind)
            K_RW, K_RO, K_CLR: rd_val = q_sel;
            K_CC:              rd_val = {q_sel[PRIV_DW-1:LIVE_W], live};
            default:           rd_val = '0;
        endcase
    end

    // Register read data and fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            acc_fault <= 1'b0;
        end else begin
            rd_data   <= rd_en ? rd_val : '0;
            acc_fault <= rd_flt || wr_flt;
        end
    end

    assert_undef_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_NONE) |=> (acc_fault && rd_data == '0));
    assert_ro_write_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !spec_mode && kind == K_RO) |=> acc_fault);
    assert_wo_read_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_WO) |=> (acc_fault && rd_data == '0));
    assert_spec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && spec_mode && !rd_en) |=> !acc_fault);
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> (!acc_fault && rd_data == '0));

endmodule

// File: tb/tb_priv_reg_bank.sv
`timescale 1ns/1ps
module tb_priv_reg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  acc_idx = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        spec_mode = 1'b0;
    logic [63:0] rd_data;
    logic        acc_fault;

    int errors = 0;
    int checks = 0;
    logic [31:0] live_m;
    logic [63:0] model [32];

    always #2 clk = ~clk;

    priv_reg_bank dut (
        .clk(clk), .rst_n(rst_n), .acc_idx(acc_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .spec_mode(spec_mode), .rd_data(rd_data), .acc_fault(acc_fault)
    );

    // Reference live count, from R10.
    always @(posedge clk) begin
        if (!rst_n) live_m <= '0;
        else        live_m <= live_m + 32'd1;
    end

    // Kinds: 0 undefined, 1 rw, 2 ro, 3 wo, 4 clr, 5 counter.
    function automatic int bkind(input int i);
        if (i >= 27) return 0;
        if (i == 26) return 5;
        if (i == 24 || i == 25) return 3;
        if (i >= 21) return 2;
        if (i == 19 || i == 20) return 4;
        return 1;
    endfunction

    function automatic logic [63:0] bmask(input int i);
        if (i == 10) return 64'hFFFF_FFFF_FFFF_FFFD;
        if (i == 11 || i == 12) return 64'hF;
        if (i == 13 || i == 14) return 64'h18;
        if (i == 15 || i == 16) return 64'h3F;
        if (i == 17) return 64'h7F0;
        if (i == 18) return 64'hFE00_0000_0000_0000;
        return 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    function automatic string tag_of(input int i);
        if (i <= 9)  return "R2";
        if (i == 10) return "R3";
        if (i <= 18) return "R4";
        if (i <= 20) return "R5";
        if (i <= 23) return "R6";
        if (i <= 25) return "R7";
        if (i == 26) return "R10";
        return "R8";
    endfunction

    function automatic logic [63:0] exp_read(input int i, input logic [31:0] lv);
        case (bkind(i))
            1, 2, 4: return model[i];
            5:       return {model[i][63:32], lv};
            default: return 64'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(input int i, input logic [63:0] d, input bit w, input bit r,
                          input bit s, output logic [63:0] q, output logic f,
                          output logic [31:0] lv);
        @(negedge clk);
        acc_idx = 5'(i); wr_data = d; wr_en = w; rd_en = r; spec_mode = s;
        lv = live_m;
        @(negedge clk);
        q = rd_data; f = acc_fault;
        wr_en = 1'b0; rd_en = 1'b0; spec_mode = 1'b0;
    endtask

    task automatic do_read(input int i, input string tag);
        logic [63:0] q; logic f; logic [31:0] lv; logic ef; logic [63:0] e;
        access(i, 64'h0, 1'b0, 1'b1, 1'b0, q, f, lv);
        e  = exp_read(i, lv);
        ef = (bkind(i) == 0 || bkind(i) == 3);
        chk(q == e, tag, $sformatf("read data idx %0d", i), q, e);
        chk(f == ef, tag, $sformatf("read fault idx %0d", i), 64'(f), 64'(ef));
    endtask

    task automatic do_write(input int i, input logic [63:0] d, input bit s);
        logic [63:0] q; logic f; logic [31:0] lv; logic ef; int k;
        access(i, d, 1'b1, 1'b0, s, q, f, lv);
        k  = bkind(i);
        ef = !s && (k == 0 || k == 2);
        chk(f == ef, s ? "R9" : tag_of(i), $sformatf("write fault idx %0d", i),
            64'(f), 64'(ef));
        if (!s) begin
            case (k)
                1:    model[i] = d & bmask(i);
                3, 5: model[i] = d;
                4:    model[i] = 64'h0;
                default: ;
            endcase
        end
    endtask

    initial begin
        logic [63:0] q; logic f; logic [31:0] lv;
        for (int i = 0; i < 32; i++) model[i] = 64'h0;
        model[8] = 64'h4000;
        model[9] = 64'h6;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents across every index.
        for (int i = 0; i < 32; i++) do_read(i, "R1");

        // Two complementary patterns through every index.
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 32; i++) begin
                logic [63:0] pat;
                pat = (p == 0) ? 64'hA5A5_5A5A_F00F_3CC3 : 64'h5A5A_A5A5_0FF0_C33C;
                pat = pat ^ 64'(i);
                do_write(i, pat, 1'b0);
                do_read(i, tag_of(i));
            end
        end

        // R9: speculative writes leave every register unchanged.
        for (int i = 0; i < 32; i++) begin
            do_write(i, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
            do_read(i, "R9");
        end

        // R11: idle cycle gives zero outputs.
        @(negedge clk);
        @(negedge clk);
        chk(rd_data == 64'h0 && !acc_fault, "R11", "idle outputs",
            rd_data, 64'h0);

        // R10: counter reads at spread times with a new upper half.
        do_write(26, 64'h1234_5678_9ABC_DEF0, 1'b0);
        for (int t = 0; t < 6; t++) begin
            repeat (t * 37) @(negedge clk);
            do_read(26, "R10");
        end
        access(26, 64'h0, 1'b0, 1'b1, 1'b0, q, f, lv);
        chk(q[63:32] == 32'h1234_5678, "R10", "upper half kept", 64'(q[63:32]),
            64'h1234_5678);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL R11 watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule